// File: doc/BRIEF.md
# Vector AXPY Streaming Unit

This block is a small vector datapath built to evaluate `Y = a*X + Y` over 16-bit signed integers with wrap-around arithmetic. It keeps four vector registers, each a first-in first-out queue of up to 64 elements. Loading a register appends memory words at its tail. Every arithmetic or store operation consumes elements from the head of its source registers. One element moves per clock, so once a stream has started, one result per cycle reaches the destination queue or memory.

Commands arrive on a valid/ready handshake, and only one command runs at a time. `cmd_ready` is the inverse of `busy`. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. A command presented while `cmd_ready` is low is not taken, and the block keeps no record of it. A caller that wants it executed must hold `cmd_valid` until the handshake completes.

The memory side connects to a plain synchronous single-port RAM:
- The RAM samples `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` on each rising edge.
- For a read, it returns `mem_rdata` in the following cycle.
- The port has no back-pressure.

The fused multiply-add command chains the scaled product directly into the adder. A complete AXPY is therefore: load a, load X, load Y, fused op, store.

Top module: `vaxpy_unit`

## Requirements
- R1: After reset, `busy` is low, `cmd_ready` is high, `mem_req` is low, all four queues are empty, the length register is 0 and the scalar register is 0.
- R2: A command is taken only on an edge where `cmd_valid` and `cmd_ready` are both high. A command presented while busy leaves the scalar and length registers, the queues and memory unchanged.
- R3: Opcode 0 loads the scalar from `cmd_data`. Opcode 6 loads the length register from `cmd_data` read as unsigned, clamped to 64. Opcode 7 does nothing. None of these three raises `busy`.
- R4: LOAD (opcode 1) requests addresses base, base+1, and so on, one per cycle, starting in the cycle after acceptance. Each returned word is appended to the destination queue in order. `busy` lasts length+1 cycles.
- R5: MUL (opcode 2) pops `cmd_src_a` once per cycle and appends the low 16 bits of scalar times element to `cmd_dst`. `busy` lasts length cycles.
- R6: ADD (opcode 3) pops the heads of `cmd_src_a` and `cmd_src_b` and appends their wrapping sum. If both fields name the same register, its head is used as both operands and is popped once.
- R7: MULADD (opcode 5) appends, in one pass, the truncated product of the scalar and the `cmd_src_a` head, plus the `cmd_src_b` head, with wrap-around.
- R8: STORE (opcode 4) writes the head of `cmd_src_a` to address base+k during cycle k+1 after acceptance and pops that element. This gives one write per cycle, and `busy` lasts length cycles.
- R9: While the length register is 0, vector opcodes (1 to 5) finish at once. They make no memory access, leave every queue unchanged and do not raise `busy`.
- R10: Addresses advance by one per element and wrap modulo 256.
- R11: A queue holds up to 64 elements and yields them in arrival order. A second load appends behind the elements already present. A register may be its own destination, since pop and push happen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (inverse of busy) |
| cmd_op | input | 3 | Opcode |
| cmd_dst | input | 2 | Destination vector register |
| cmd_src_a | input | 2 | First source vector register |
| cmd_src_b | input | 2 | Second source vector register |
| cmd_addr | input | 8 | Base memory address for load and store |
| cmd_data | input | 16 | Scalar value or length value |
| busy | output | 1 | A vector command is running |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after a read request |

## Verification
For a command accepted on edge A, the first memory request or queue step is visible in the cycle after A. A store's k-th write is driven in cycle A+1+k. A load's k-th word is appended at edge A+2+k, so `busy` falls after edge A+length+1 for loads and after A+length for the other vector opcodes. The bench reference model advances on the same edges with plain queues. It is compared against `busy`, `cmd_ready`, the request, the address and the write data at every falling edge, half a cycle after the registers settle. Hand-computed memory contents are then compared after each command sequence has drained.

// File: rtl/vaxpy_pkg.sv
package vaxpy_pkg;

  typedef enum logic [2:0] {
    OP_SCALAR = 3'd0,
    OP_LOAD   = 3'd1,
    OP_MUL    = 3'd2,
    OP_ADD    = 3'd3,
    OP_STORE  = 3'd4,
    OP_MULADD = 3'd5,
    OP_SETLEN = 3'd6,
    OP_NOP    = 3'd7
  } vop_e;

  typedef enum logic [1:0] {
    LANE_MUL = 2'd0,
    LANE_ADD = 2'd1,
    LANE_MAC = 2'd2
  } lane_mode_e;

  function automatic logic is_stream_op(vop_e op);
    return op inside {OP_LOAD, OP_MUL, OP_ADD, OP_STORE, OP_MULADD};
  endfunction

  function automatic logic pops_a(vop_e op);
    return op inside {OP_MUL, OP_ADD, OP_STORE, OP_MULADD};
  endfunction

  function automatic logic pops_b(vop_e op);
    return op inside {OP_ADD, OP_MULADD};
  endfunction

  function automatic logic computes(vop_e op);
    return op inside {OP_MUL, OP_ADD, OP_MULADD};
  endfunction

endpackage

// File: rtl/vaxpy_vreg_fifo.sv
module vaxpy_vreg_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             empty, do_pop, do_push;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = slots[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_q] <= din;
  end

endmodule

// File: rtl/vaxpy_lane.sv
module vaxpy_lane
  import vaxpy_pkg::*;
#(
  parameter int ELEM_W = 16
) (
  input  lane_mode_e        mode,
  input  logic [ELEM_W-1:0] scalar,
  input  logic [ELEM_W-1:0] opa,
  input  logic [ELEM_W-1:0] opb,
  output logic [ELEM_W-1:0] result
);
  logic [ELEM_W-1:0] prod;

  // Low half of the product is identical for signed and unsigned operands.
  assign prod = scalar * opa;

  always_comb begin
    case (mode)
      LANE_MUL: result = prod;
      LANE_ADD: result = opa + opb;
      default:  result = prod + opb;
    endcase
  end

endmodule

// File: rtl/vaxpy_seq.sv
module vaxpy_seq
  import vaxpy_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ELEM_W  = 16,
  parameter int REG_W   = 2,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  vop_e              cmd_op,
  input  logic [REG_W-1:0]  cmd_dst,
  input  logic [REG_W-1:0]  cmd_src_a,
  input  logic [REG_W-1:0]  cmd_src_b,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ELEM_W-1:0] cmd_data,
  output logic              cmd_ready,
  output logic              busy,
  output logic [ELEM_W-1:0] scalar,
  output logic [LEN_W-1:0]  len_cur,
  output vop_e              run_op,
  output logic [REG_W-1:0]  run_dst,
  output logic [REG_W-1:0]  run_src_a,
  output logic [REG_W-1:0]  run_src_b,
  output logic              issue,
  output logic              load_ret,
  output logic [ADDR_W-1:0] addr
);
  logic              busy_q, pend_q;
  vop_e              op_q;
  logic [REG_W-1:0]  dst_q, sa_q, sb_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  cnt_q, run_len_q, len_q;
  logic [ELEM_W-1:0] scal_q;
  logic              accept, done;
  logic [LEN_W-1:0]  cnt_nx;
  logic [LEN_W-1:0]  len_in;

  assign accept = cmd_valid && !busy_q;
  assign issue  = busy_q && (cnt_q != run_len_q);
  assign cnt_nx = cnt_q + 1'b1;
  assign len_in = (cmd_data > ELEM_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : cmd_data[LEN_W-1:0];
  assign done   = (op_q == OP_LOAD) ? (!issue && pend_q) : (issue && cnt_nx == run_len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pend_q    <= 1'b0;
      op_q      <= OP_NOP;
      dst_q     <= '0;
      sa_q      <= '0;
      sb_q      <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      run_len_q <= '0;
      len_q     <= '0;
      scal_q    <= '0;
    end else if (busy_q) begin
      if (issue) cnt_q <= cnt_nx;
      pend_q <= issue && (op_q == OP_LOAD);
      if (done) busy_q <= 1'b0;
    end else if (accept) begin
      case (cmd_op)
        OP_SCALAR: scal_q <= cmd_data;
        OP_SETLEN: len_q  <= len_in;
        default: begin
          if (is_stream_op(cmd_op) && len_q != '0) begin
            busy_q    <= 1'b1;
            op_q      <= cmd_op;
            dst_q     <= cmd_dst;
            sa_q      <= cmd_src_a;
            sb_q      <= cmd_src_b;
            base_q    <= cmd_addr;
            cnt_q     <= '0;
            run_len_q <= len_q;
          end
        end
      endcase
    end
  end

  assign cmd_ready = !busy_q;
  assign busy      = busy_q;
  assign scalar    = scal_q;
  assign len_cur   = len_q;
  assign run_op    = op_q;
  assign run_dst   = dst_q;
  assign run_src_a = sa_q;
  assign run_src_b = sb_q;
  assign load_ret  = pend_q;
  assign addr      = base_q + ADDR_W'(cnt_q);

endmodule

// File: rtl/vaxpy_unit.sv
module vaxpy_unit
  import vaxpy_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ELEM_W  = 16,
  parameter int NREG    = 4,
  parameter int MAX_LEN = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(NREG)-1:0]  cmd_dst,
  input  logic [$clog2(NREG)-1:0]  cmd_src_a,
  input  logic [$clog2(NREG)-1:0]  cmd_src_b,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [ELEM_W-1:0]        cmd_data,
  output logic                     busy,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [ELEM_W-1:0]        mem_wdata,
  input  logic [ELEM_W-1:0]        mem_rdata
);
  localparam int REG_W = $clog2(NREG);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  vop_e              run_op;
  logic [REG_W-1:0]  run_dst, run_src_a, run_src_b;
  logic              issue, load_ret;
  logic [ELEM_W-1:0] scal_cur;
  logic [LEN_W-1:0]  len_cur;
  logic [ADDR_W-1:0] seq_addr;

  logic              pop_a, pop_b, push_any;
  logic [ELEM_W-1:0] push_data, lane_out, head_a, head_b;
  logic [ELEM_W-1:0] heads [NREG];
  logic [NREG-1:0]   push_vec, pop_vec, full_vec;
  lane_mode_e        lane_mode;

  vaxpy_seq #(
    .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .REG_W(REG_W),
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(vop_e'(cmd_op)),
    .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .busy(busy),
    .scalar(scal_cur), .len_cur(len_cur),
    .run_op(run_op), .run_dst(run_dst),
    .run_src_a(run_src_a), .run_src_b(run_src_b),
    .issue(issue), .load_ret(load_ret), .addr(seq_addr)
  );

  assign pop_a    = issue && pops_a(run_op);
  assign pop_b    = issue && pops_b(run_op);
  assign push_any = load_ret || (issue && computes(run_op));

  assign lane_mode = (run_op == OP_ADD)    ? LANE_ADD :
                     (run_op == OP_MULADD) ? LANE_MAC : LANE_MUL;

  vaxpy_lane #(.ELEM_W(ELEM_W)) lane_i (
    .mode(lane_mode), .scalar(scal_cur),
    .opa(head_a), .opb(head_b), .result(lane_out)
  );

  assign push_data = load_ret ? mem_rdata : lane_out;

  for (genvar g = 0; g < NREG; g++) begin : g_vreg
    assign push_vec[g] = push_any && (run_dst == REG_W'(g));
    assign pop_vec[g]  = (pop_a && run_src_a == REG_W'(g)) ||
                         (pop_b && run_src_b == REG_W'(g));
    vaxpy_vreg_fifo #(.DEPTH(MAX_LEN), .W(ELEM_W)) q_i (
      .clk(clk), .rst_n(rst_n),
      .push(push_vec[g]), .pop(pop_vec[g]),
      .din(push_data), .head(heads[g]), .full(full_vec[g])
    );
  end

  assign head_a = heads[run_src_a];
  assign head_b = heads[run_src_b];

  assign mem_req   = issue && (run_op == OP_LOAD || run_op == OP_STORE);
  assign mem_we    = issue && (run_op == OP_STORE);
  assign mem_addr  = seq_addr;
  assign mem_wdata = head_a;

endmodule

// File: rtl/vaxpy_unit_chk.sv
module vaxpy_unit_chk #(
  parameter int ADDR_W  = 8,
  parameter int ELEM_W  = 16,
  parameter int NREG    = 4,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ELEM_W-1:0] scal_cur,
  input logic [LEN_W-1:0]  len_cur,
  input logic [NREG-1:0]   push_vec,
  input logic [NREG-1:0]   pop_vec,
  input logic [NREG-1:0]   full_vec
);
  logic taken, vec_cmd;
  assign taken   = cmd_valid && cmd_ready;
  assign vec_cmd = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_busy_holds_scalar_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(scal_cur));

  assert_len_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    len_cur <= LEN_W'(MAX_LEN));

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    taken && vec_cmd && len_cur != '0 |=> busy);

  assert_write_is_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  assert_zero_len_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    taken && len_cur == '0 |=> !busy);

  assert_unit_stride_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && busy && $past(mem_req) && $past(busy) |-> mem_addr == $past(mem_addr) + 1'b1);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vec & full_vec & ~pop_vec) == '0);

endmodule

bind vaxpy_unit vaxpy_unit_chk #(
  .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .NREG(NREG), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .scal_cur(scal_cur), .len_cur(len_cur),
  .push_vec(push_vec), .pop_vec(pop_vec), .full_vec(full_vec)
);

// File: tb/vaxpy_unit_tb_top.sv
`timescale 1ns/1ps
module vaxpy_unit_tb_top;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_dst = '0, cmd_src_a = '0, cmd_src_b = '0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        busy, mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  vaxpy_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // synchronous single-port RAM
  logic [15:0] ram [256];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  // behavioural reference model
  logic [15:0] mmem [256];
  logic [15:0] vq [NREG][$];
  bit          m_busy, m_pend;
  int          m_op, m_k, m_len, m_lenreg, m_dst, m_sa, m_sb, m_base;
  logic [15:0] m_scal, m_pval;

  function automatic logic [15:0] mul16(logic [15:0] a, logic [15:0] b);
    int p = int'($signed(a)) * int'($signed(b));
    return p[15:0];
  endfunction

  task automatic model_reset();
    m_busy = 0; m_pend = 0; m_op = 7; m_k = 0; m_len = 0; m_lenreg = 0;
    m_scal = '0;
    for (int r = 0; r < NREG; r++) vq[r].delete();
  endtask

  task automatic model_step();
    logic [15:0] x, y;
    bit iss;
    iss = m_k < m_len;
    if (m_op == 1) begin
      if (m_pend) begin vq[m_dst].push_back(m_pval); m_pend = 0; end
      if (iss) begin m_pval = mmem[(m_base + m_k) % 256]; m_pend = 1; m_k++; end
      if (m_k >= m_len && !m_pend) m_busy = 0;
    end else begin
      x = vq[m_sa][0];
      y = vq[m_sb][0];
      void'(vq[m_sa].pop_front());
      if ((m_op == 3 || m_op == 5) && m_sb != m_sa) void'(vq[m_sb].pop_front());
      case (m_op)
        2: vq[m_dst].push_back(mul16(m_scal, x));
        3: vq[m_dst].push_back(x + y);
        5: vq[m_dst].push_back(mul16(m_scal, x) + y);
        default: mmem[(m_base + m_k) % 256] = x;
      endcase
      m_k++;
      if (m_k == m_len) m_busy = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (m_busy) model_step();
    else if (cmd_valid) begin
      case (int'(cmd_op))
        0: m_scal = cmd_data;
        6: m_lenreg = (int'(cmd_data) > 64) ? 64 : int'(cmd_data);
        1, 2, 3, 4, 5: if (m_lenreg != 0) begin
          m_busy = 1; m_op = int'(cmd_op); m_dst = int'(cmd_dst);
          m_sa = int'(cmd_src_a); m_sb = int'(cmd_src_b);
          m_base = int'(cmd_addr); m_k = 0; m_len = m_lenreg;
        end
        default: ;
      endcase
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, half a cycle after the registers settle
  always @(negedge clk) begin
    if (rst_n) begin
      bit iss, e_req, e_we, ok;
      logic [7:0] e_addr;
      logic [15:0] e_wd;
      string tag;
      iss    = m_busy && (m_k < m_len);
      e_req  = iss && (m_op == 1 || m_op == 4);
      e_we   = iss && (m_op == 4);
      e_addr = 8'((m_base + m_k) % 256);
      e_wd   = e_we ? vq[m_sa][0] : '0;
      ok = (busy == m_busy) && (cmd_ready == !m_busy) && (mem_req == e_req) &&
           (mem_we == e_we) && (!e_req || mem_addr == e_addr) && (!e_we || mem_wdata == e_wd);
      case (m_busy ? m_op : 0)
        1: tag = "R4"; 2: tag = "R5"; 3: tag = "R6"; 4: tag = "R8"; 5: tag = "R7";
        default: tag = "R2";
      endcase
      check(ok, tag, {busy, cmd_ready, mem_req, mem_we, mem_addr, (mem_we ? mem_wdata : 16'h0), 28'h0},
            {m_busy, !m_busy, e_req, e_we, e_addr, e_wd, 28'h0});
    end
  end

  task automatic cmd(int op, int dst, int sa, int sb, int addr, int data);
    while (!cmd_ready) @(negedge clk);
    cmd_op = 3'(op); cmd_dst = 2'(dst); cmd_src_a = 2'(sa); cmd_src_b = 2'(sb);
    cmd_addr = 8'(addr); cmd_data = 16'(data); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic poke(int op, int data);
    cmd_op = 3'(op); cmd_data = 16'(data); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog R2 actual=%0d expected<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  logic [15:0] snap [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]  = 16'((i * 2719) ^ 16'h9A3C);
      mmem[i] = ram[i];
    end
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(busy == 1'b0 && cmd_ready && !mem_req, "R1", {busy, cmd_ready, mem_req}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R1: length is 0 after reset, vector op does nothing
    cmd(1, 0, 0, 0, 8'h00, 0);
    check(!busy && !mem_req, "R9", {busy, mem_req}, 2'b00);
    // R1: scalar is 0 after reset
    cmd(6, 0, 0, 0, 0, 2);
    cmd(1, 0, 0, 0, 8'h00, 0);
    cmd(2, 1, 0, 0, 0, 0);
    cmd(4, 0, 1, 0, 8'h40, 0);
    wait_idle();
    check(ram[8'h40] == 16'h0 && ram[8'h41] == 16'h0, "R1", {ram[8'h40], ram[8'h41]}, 32'h0);

    // AXPY with a = 3, length 8; commands poked while busy are dropped (R2)
    for (int i = 0; i < 256; i++) snap[i] = ram[i];
    cmd(6, 0, 0, 0, 0, 8);
    cmd(0, 0, 0, 0, 0, 3);
    cmd(1, 0, 0, 0, 8'h10, 0);
    poke(0, 1000);
    poke(6, 1);
    cmd(2, 1, 0, 0, 0, 0);
    cmd(1, 2, 0, 0, 8'h20, 0);
    cmd(3, 3, 1, 2, 0, 0);
    cmd(4, 0, 3, 0, 8'h20, 0);
    wait_idle();
    for (int i = 0; i < 8; i++)
      check(ram[8'h20 + i] == 16'(mul16(16'd3, snap[8'h10 + i]) + snap[8'h20 + i]), "R6",
            ram[8'h20 + i], 16'(mul16(16'd3, snap[8'h10 + i]) + snap[8'h20 + i]));

    // R7: chained multiply-add with a negative scalar
    for (int i = 0; i < 256; i++) snap[i] = ram[i];
    cmd(0, 0, 0, 0, 0, 16'hFFFE);
    cmd(1, 0, 0, 0, 8'h30, 0);
    cmd(1, 1, 0, 0, 8'h50, 0);
    cmd(5, 2, 0, 1, 0, 0);
    cmd(4, 0, 2, 0, 8'h50, 0);
    wait_idle();
    for (int i = 0; i < 8; i++)
      check(ram[8'h50 + i] == 16'(mul16(16'hFFFE, snap[8'h30 + i]) + snap[8'h50 + i]), "R7",
            ram[8'h50 + i], 16'(mul16(16'hFFFE, snap[8'h30 + i]) + snap[8'h50 + i]));

    // R6: both sources name the same register
    for (int i = 0; i < 256; i++) snap[i] = ram[i];
    cmd(1, 0, 0, 0, 8'h60, 0);
    cmd(3, 1, 0, 0, 0, 0);
    cmd(4, 0, 1, 0, 8'h60, 0);
    wait_idle();
    for (int i = 0; i < 8; i++)
      check(ram[8'h60 + i] == 16'(snap[8'h60 + i] << 1), "R6", ram[8'h60 + i], 16'(snap[8'h60 + i] << 1));

    // R11: second load appends behind the first
    for (int i = 0; i < 256; i++) snap[i] = ram[i];
    cmd(6, 0, 0, 0, 0, 3);
    cmd(1, 3, 0, 0, 8'h70, 0);
    cmd(6, 0, 0, 0, 0, 2);
    cmd(1, 3, 0, 0, 8'h78, 0);
    cmd(6, 0, 0, 0, 0, 5);
    cmd(4, 0, 3, 0, 8'h90, 0);
    wait_idle();
    check(ram[8'h90] == snap[8'h70] && ram[8'h91] == snap[8'h71] && ram[8'h92] == snap[8'h72] &&
          ram[8'h93] == snap[8'h78] && ram[8'h94] == snap[8'h79], "R11",
          {ram[8'h90], ram[8'h93], ram[8'h94]}, {snap[8'h70], snap[8'h78], snap[8'h79]});

    // R3 clamp to 64, R10 wrap, R11 full queues and self-destination
    for (int i = 0; i < 256; i++) snap[i] = ram[i];
    cmd(6, 0, 0, 0, 0, 200);
    cmd(0, 0, 0, 0, 0, 5);
    cmd(1, 0, 0, 0, 8'hE0, 0);
    cmd(1, 1, 0, 0, 8'h00, 0);
    cmd(5, 1, 0, 1, 0, 0);
    cmd(4, 0, 1, 0, 8'hC0, 0);
    wait_idle();
    for (int i = 0; i < 64; i++)
      check(ram[(8'hC0 + i) % 256] == 16'(mul16(16'd5, snap[(8'hE0 + i) % 256]) + snap[i]), "R10",
            ram[(8'hC0 + i) % 256], 16'(mul16(16'd5, snap[(8'hE0 + i) % 256]) + snap[i]));

    // R3: opcode 7 does nothing
    cmd(7, 0, 0, 0, 0, 0);
    check(!busy && !mem_req, "R3", {busy, mem_req}, 2'b00);
    wait_idle();

    for (int i = 0; i < 256; i++)
      check(ram[i] === mmem[i], "R8", ram[i], mmem[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule